// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block sits between a 32-bit processor core and an external data bus whose width is decided per bus cycle. The core hands over one request: an aligned 32-bit word, four active-low byte-lane enables, a direction flag and a one-cycle start strobe. The adapter runs the request on the bus and samples a narrow-bus input, `bus_narrow`, at the moment the cycle is acknowledged. A narrow device moves only bits 15..0. If the request then still has bytes in the upper half, the adapter runs a second sub-cycle that carries those bytes over the lower lanes.

Write data is steered before the width is known. Whenever the active bytes sit only in the upper half, or a second sub-cycle is running, the upper halfword is also presented on the lower lanes. A narrow device can therefore take the data without any extra work. For reads, the halves from each sub-cycle are merged into one word for the core. The core gets a single-cycle done pulse only after the last sub-cycle has been acknowledged.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset `bus_cyc`, `bus_start`, `bus_wdata_oe` and `core_done` are 0, `bus_be_n` is 4'hF and `core_rdata` is 0.
- R2: The first sub-cycle presents the request's byte enables and direction unchanged. Enable bit i (active low) covers data bits 8i+7..8i. The enables and data stay stable for the whole sub-cycle.
- R3: Write data on the first sub-cycle equals the request word, except when enable bits 1..0 are both high (no lower byte active). In that case bits 15..0 carry a copy of bits 31..16.
- R4: `bus_wdata_oe` is 1 on every cycle of a write sub-cycle, whatever the bus width, and 0 during reads and while idle.
- R5: `bus_ready` is ignored on the first cycle of every sub-cycle (the cycle where `bus_start` is 1). A sub-cycle therefore lasts at least two cycles.
- R6: A request completes in one sub-cycle if `bus_narrow` is 0 when it is acknowledged, or if only lower enables (1..0) are active.
- R7: If `bus_narrow` is 1 at the acknowledge and both halves are active, a second sub-cycle follows. It asserts only the originally active enables among bits 3..2, and its write data carries bits 31..16 on both halves.
- R8: On a split read, `core_rdata[15:0]` comes from bus bits 15..0 of the first sub-cycle and `core_rdata[31:16]` from bus bits 15..0 of the second.
- R9: If `bus_narrow` is 1 at the acknowledge and only upper enables are active, the request ends after one sub-cycle, and the upper bytes of `core_rdata` are taken from bus bits 15..0.
- R10: `core_done` is a one-cycle pulse. It rises the cycle after the final acknowledge, so each sub-cycle contributes 2 + wait cycles. Bytes of `core_rdata` whose enable is inactive read as 0.
- R11: The value of `bus_narrow` during the second sub-cycle has no effect.
- R12: `bus_start` is 1 for exactly the first cycle of each sub-cycle. A request produces one or two sub-cycles, as R6, R7 and R9 give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | One-cycle request strobe from the core, accepted while idle |
| core_write | input | 1 | 1 = write, 0 = read |
| core_be_n | input | 4 | Active-low byte-lane enables of the request |
| core_wdata | input | 32 | Write word from the core |
| core_done | output | 1 | One-cycle pulse: request finished |
| core_rdata | output | 32 | Assembled read word, valid with `core_done` |
| bus_cyc | output | 1 | A sub-cycle is in progress |
| bus_start | output | 1 | First cycle of a sub-cycle |
| bus_write | output | 1 | Direction of the current sub-cycle |
| bus_be_n | output | 4 | Active-low byte enables on the bus |
| bus_wdata | output | 32 | Steered write data |
| bus_wdata_oe | output | 1 | Data lines driven by this side |
| bus_ready | input | 1 | Sub-cycle acknowledge |
| bus_narrow | input | 1 | Device is 16 bits wide, sampled with the acknowledge |
| bus_rdata | input | 32 | Read data from the bus |

## Verification
The assertions take three things for granted. The core raises `core_req` only while the adapter is idle. Every request has a non-empty set of active enables with no gap between them. `bus_ready` and `bus_narrow` matter only while `bus_cyc` is 1. The stimulus keeps to these by waiting for each done pulse before the next request, and by building enables only from the ten contiguous lane patterns. It drops `bus_ready` once the request completes. Within those bounds it drives a held-high ready on the ignored first cycle, inserts wait cycles, and flips `bus_narrow` during second sub-cycles.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUB1 = 2'd1,
        ST_SUB2 = 2'd2
    } dbs_state_e;

    typedef struct packed {
        dbs_state_e state;
        logic       first;
        logic       done;
    } dbs_seq_t;

endpackage

// File: rtl/dbs_req_hold.sv
`timescale 1ns/1ps
module dbs_req_hold #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be_n,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              wr_q_o,
    output logic [LANES-1:0]  be_n_q_o,
    output logic [DATA_W-1:0] wd_q_o
);

    typedef struct packed {
        logic              wr;
        logic [LANES-1:0]  be_n;
        logic [DATA_W-1:0] wd;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (accept) begin
            hold_d.wr   = req_write;
            hold_d.be_n = req_be_n;
            hold_d.wd   = req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.wr   <= 1'b0;
            hold_q.be_n <= '1;
            hold_q.wd   <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign wr_q_o   = hold_q.wr;
    assign be_n_q_o = hold_q.be_n;
    assign wd_q_o   = hold_q.wd;

endmodule

// File: rtl/dbs_sequencer.sv
`timescale 1ns/1ps
module dbs_sequencer
    import dbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       has_lo,
    input  logic       has_hi,
    input  logic       ready,
    input  logic       narrow,
    output dbs_state_e state_o,
    output logic       first_o,
    output logic       done_o,
    output logic       accept_o,
    output logic       cap1_o,
    output logic       cap2_o,
    output logic       split_o
);

    dbs_seq_t seq_d, seq_q;
    logic     complete;
    logic     split;

    // an acknowledge counts only after the first cycle of a sub-cycle
    assign complete = (seq_q.state != ST_IDLE) && !seq_q.first && ready;
    assign split    = (seq_q.state == ST_SUB1) && complete && narrow && has_lo && has_hi;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req) begin
                    seq_d.state = ST_SUB1;
                    seq_d.first = 1'b1;
                end
            end
            ST_SUB1: begin
                if (seq_q.first) begin
                    seq_d.first = 1'b0;
                end else if (split) begin
                    seq_d.state = ST_SUB2;
                    seq_d.first = 1'b1;
                end else if (complete) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            ST_SUB2: begin
                if (seq_q.first) begin
                    seq_d.first = 1'b0;
                end else if (complete) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.first = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state <= ST_IDLE;
            seq_q.first <= 1'b0;
            seq_q.done  <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o  = seq_q.state;
    assign first_o  = seq_q.first;
    assign done_o   = seq_q.done;
    assign accept_o = (seq_q.state == ST_IDLE) && req;
    assign cap1_o   = (seq_q.state == ST_SUB1) && complete;
    assign cap2_o   = (seq_q.state == ST_SUB2) && complete;
    assign split_o  = split;

    // R10: completion strobe lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);

    // R10: done only follows an acknowledge taken in a sub-cycle
    p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |-> ($past(ready) && $past(seq_q.state) != ST_IDLE));

    // R5: acknowledge on the first cycle of a sub-cycle changes nothing
    p_first_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state != ST_IDLE && seq_q.first) |=>
        (seq_q.state == $past(seq_q.state) && !seq_q.done));

    // R12: start marker never lasts two cycles
    p_start_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.first |=> !seq_q.first);

    // R7: a second sub-cycle only follows a narrow acknowledge
    p_sub2_needs_narrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == ST_SUB2 && seq_q.first) |-> ($past(narrow) && $past(ready)));

endmodule

// File: rtl/dbs_wr_steer.sv
`timescale 1ns/1ps
module dbs_wr_steer #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int HALF_LANES = LANES / 2
) (
    input  logic [LANES-1:0]  be_n_q,
    input  logic [DATA_W-1:0] wd_q,
    input  logic              has_lo,
    input  logic              second,
    output logic [LANES-1:0]  be_n_o,
    output logic [DATA_W-1:0] wd_o
);

    logic dup;

    // upper halfword mirrored when no lower byte exists or in the second pass
    assign dup = second || !has_lo;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF_LANES) begin : g_low
            assign be_n_o[i]        = second ? 1'b1 : be_n_q[i];
            assign wd_o[8*i +: 8]   = dup ? wd_q[8*(i+HALF_LANES) +: 8] : wd_q[8*i +: 8];
        end else begin : g_high
            assign be_n_o[i]        = be_n_q[i];
            assign wd_o[8*i +: 8]   = wd_q[8*i +: 8];
        end
    end

endmodule

// File: rtl/dbs_rd_merge.sv
`timescale 1ns/1ps
module dbs_rd_merge #(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int HALF_LANES = LANES / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  be_n_q,
    input  logic              cap1,
    input  logic              cap2,
    input  logic              narrow,
    input  logic              split,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] acc_d, acc_q;
    logic [7:0]        lane_nx [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF_LANES) begin : g_low
            assign lane_nx[i] = !cap1     ? acc_q[8*i +: 8] :
                                be_n_q[i] ? 8'h00 :
                                            bus_rdata[8*i +: 8];
        end else begin : g_high
            logic [7:0] first_pick;
            assign first_pick = be_n_q[i] ? 8'h00 :
                                split     ? 8'h00 :
                                narrow    ? bus_rdata[8*(i-HALF_LANES) +: 8] :
                                            bus_rdata[8*i +: 8];
            assign lane_nx[i] = cap1 ? first_pick :
                                cap2 ? (be_n_q[i] ? 8'h00 : bus_rdata[8*(i-HALF_LANES) +: 8]) :
                                       acc_q[8*i +: 8];
        end
    end

    always_comb begin
        acc_d = acc_q;
        for (int i = 0; i < LANES; i++) begin
            acc_d[8*i +: 8] = lane_nx[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign rdata_o = acc_q;

    // R8: the two captures of one request never coincide
    p_capture_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap1 && cap2));

endmodule

// File: rtl/bus_width_adapter.sv
`timescale 1ns/1ps
module bus_width_adapter
    import dbs_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int HALF_LANES = LANES / 2,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req,
    input  logic              core_write,
    input  logic [LANES-1:0]  core_be_n,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_done,
    output logic [DATA_W-1:0] core_rdata,
    output logic              bus_cyc,
    output logic              bus_start,
    output logic              bus_write,
    output logic [LANES-1:0]  bus_be_n,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic              bus_ready,
    input  logic              bus_narrow,
    input  logic [DATA_W-1:0] bus_rdata
);

    dbs_state_e        state;
    logic              first, accept, cap1, cap2, split;
    logic              wr_q;
    logic [LANES-1:0]  be_n_q, steer_be_n;
    logic [DATA_W-1:0] wd_q, steer_wd;
    logic              has_lo, has_hi, second;

    assign has_lo = ~&be_n_q[HALF_LANES-1:0];
    assign has_hi = ~&be_n_q[LANES-1:HALF_LANES];
    assign second = (state == ST_SUB2);

    dbs_req_hold #(.DATA_W(DATA_W)) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (core_write),
        .req_be_n  (core_be_n),
        .req_wdata (core_wdata),
        .wr_q_o    (wr_q),
        .be_n_q_o  (be_n_q),
        .wd_q_o    (wd_q)
    );

    dbs_sequencer seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (core_req),
        .has_lo   (has_lo),
        .has_hi   (has_hi),
        .ready    (bus_ready),
        .narrow   (bus_narrow),
        .state_o  (state),
        .first_o  (first),
        .done_o   (core_done),
        .accept_o (accept),
        .cap1_o   (cap1),
        .cap2_o   (cap2),
        .split_o  (split)
    );

    dbs_wr_steer #(.DATA_W(DATA_W)) steer_i (
        .be_n_q (be_n_q),
        .wd_q   (wd_q),
        .has_lo (has_lo),
        .second (second),
        .be_n_o (steer_be_n),
        .wd_o   (steer_wd)
    );

    dbs_rd_merge #(.DATA_W(DATA_W)) merge_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .be_n_q    (be_n_q),
        .cap1      (cap1),
        .cap2      (cap2),
        .narrow    (bus_narrow),
        .split     (split),
        .bus_rdata (bus_rdata),
        .rdata_o   (core_rdata)
    );

    assign bus_cyc      = (state != ST_IDLE);
    assign bus_start    = bus_cyc && first;
    assign bus_write    = bus_cyc && wr_q;
    assign bus_wdata_oe = bus_cyc && wr_q;
    assign bus_be_n     = bus_cyc ? steer_be_n : '1;
    assign bus_wdata    = steer_wd;

    // R4: data lines driven on writes only, at any width
    p_oe_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_wdata_oe == bus_write));

    // R1: idle bus keeps lanes off and data undriven
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (!bus_wdata_oe && (&bus_be_n)));

    // R2: lanes and data hold through a sub-cycle
    p_hold_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_start) |-> ($stable(bus_be_n) && $stable(bus_wdata)));

    // R3: writes with no lower lane mirror the upper halfword
    p_dup_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && (&bus_be_n[HALF_LANES-1:0])) |->
        (bus_wdata[HALF_W-1:0] == bus_wdata[DATA_W-1:HALF_W]));

    // R7: second sub-cycle uses upper enables only
    p_sub2_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && second) |-> ((&bus_be_n[HALF_LANES-1:0]) && !(&bus_be_n)));

endmodule

// File: tb/bus_width_adapter_tb_top.sv
`timescale 1ns/1ps
module bus_width_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_write = 1'b0;
    logic [3:0]  core_be_n = 4'hF;
    logic [31:0] core_wdata = '0;
    logic        core_done;
    logic [31:0] core_rdata;
    logic        bus_cyc, bus_start, bus_write, bus_wdata_oe;
    logic [3:0]  bus_be_n;
    logic [31:0] bus_wdata;
    logic        bus_ready = 1'b0, bus_narrow = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #10 clk = ~clk;

    bus_width_adapter dut_i (
        .clk(clk), .rst_n(rst_n),
        .core_req(core_req), .core_write(core_write), .core_be_n(core_be_n),
        .core_wdata(core_wdata), .core_done(core_done), .core_rdata(core_rdata),
        .bus_cyc(bus_cyc), .bus_start(bus_start), .bus_write(bus_write),
        .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_ready(bus_ready), .bus_narrow(bus_narrow), .bus_rdata(bus_rdata)
    );

    int cyc_cnt = 0;
    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    int n_run = 0, n_fail = 0;

    typedef struct {
        logic [31:0] rd;
        int          due;
        bit          wr;
        string       tag;
    } exp_t;
    exp_t sb[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each done pulse
    always @(negedge clk) begin
        if (rst_n && core_done) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R10", "done without request", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc_cnt == e.due, "R10", "done cycle", cyc_cnt, e.due);
                if (!e.wr) chk(core_rdata == e.rd, e.tag, "read word", core_rdata, e.rd);
            end
        end
    end

    task automatic run_txn(input bit wr, input logic [3:0] be_n, input logic [31:0] wd,
                           input bit nar, input int w, input bit hold,
                           input logic [31:0] ra, input logic [31:0] rb);
        bit lo, hi, spl, seen;
        int nsub, sub, cnt;
        logic [31:0] exp_rd, wd1, wd2;
        logic [3:0]  be2;
        exp_t e;
        lo   = ~&be_n[1:0];
        hi   = ~&be_n[3:2];
        spl  = nar && lo && hi;
        nsub = spl ? 2 : 1;
        for (int b = 0; b < 4; b++) begin
            if (be_n[b])       exp_rd[8*b +: 8] = 8'h00;
            else if (b < 2)    exp_rd[8*b +: 8] = ra[8*b +: 8];
            else if (!nar)     exp_rd[8*b +: 8] = ra[8*b +: 8];
            else if (spl)      exp_rd[8*b +: 8] = rb[8*(b-2) +: 8];
            else               exp_rd[8*b +: 8] = ra[8*(b-2) +: 8];
        end
        wd1 = lo ? wd : {wd[31:16], wd[31:16]};
        wd2 = {wd[31:16], wd[31:16]};
        be2 = {be_n[3:2], 2'b11};
        @(negedge clk);
        core_req   = 1'b1;
        core_write = wr;
        core_be_n  = be_n;
        core_wdata = wd;
        e.rd  = exp_rd;
        e.due = cyc_cnt + nsub * (2 + w) + 1;
        e.wr  = wr;
        e.tag = !nar ? "R6" : spl ? "R8 R11" : !lo ? "R9" : "R6";
        sb.push_back(e);
        sub = 0; cnt = 0; seen = 0;
        for (int g = 0; g < 40 && !seen; g++) begin
            @(negedge clk);
            core_req = 1'b0;
            if (core_done) begin
                seen = 1;
            end else if (bus_start) begin
                sub++;
                cnt = 0;
                if (sub == 1) begin
                    chk(bus_be_n == be_n, "R2", "first enables", {28'd0, bus_be_n}, {28'd0, be_n});
                    chk(bus_write == wr, "R2", "direction", {31'd0, bus_write}, {31'd0, wr});
                    if (wr) chk(bus_wdata == wd1, "R3", "first write data", bus_wdata, wd1);
                end else begin
                    chk(bus_be_n == be2, "R7", "second enables", {28'd0, bus_be_n}, {28'd0, be2});
                    if (wr) chk(bus_wdata == wd2, "R7", "second write data", bus_wdata, wd2);
                end
                chk(bus_wdata_oe == wr, "R4", "data drive", {31'd0, bus_wdata_oe}, {31'd0, wr});
                bus_narrow = (sub == 1) ? nar : ~nar;  // R11: flipped in second pass
                bus_rdata  = (sub == 1) ? ra : rb;
                bus_ready  = hold;                      // R5: ignored here
            end else if (bus_cyc) begin
                cnt++;
                chk(bus_wdata_oe == wr, "R4", "data drive held", {31'd0, bus_wdata_oe}, {31'd0, wr});
                bus_ready = (cnt - 1 >= w);
            end
        end
        bus_ready = 1'b0;
        chk(seen, "R10", "done seen", {31'd0, seen}, 32'd1);
        chk(sub == nsub, "R12", "sub-cycle count", sub, nsub);
    endtask

    initial begin
        #3000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset held
        chk(!bus_cyc && !bus_start && !bus_wdata_oe && !core_done, "R1", "idle flags",
            {28'd0, bus_cyc, bus_start, bus_wdata_oe, core_done}, 32'd0);
        chk(bus_be_n == 4'hF, "R1", "reset enables", {28'd0, bus_be_n}, 32'hF);
        chk(core_rdata == 32'd0, "R1", "reset read word", core_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int st = 0; st < 4; st++) begin
            for (int len = 1; len <= 4 - st; len++) begin
                logic [3:0] be;
                be = ~(4'((1 << len) - 1) << st);
                for (int k = 0; k < 8; k++) begin
                    run_txn(k[0], be, $urandom(), k[1], k[2] ? 2 : 0,
                            (st + len + k) % 2 == 0, $urandom(), $urandom());
                end
            end
        end
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule